// File: doc/BRIEF.md
# SDRAM Mode Register Programmer

This block turns a request for a new SDRAM operating mode into a mode-register-set command on the memory command bus. A request carries three raw field codes: burst length, addressing order (sequential or interleaved) and CAS latency. The block checks that the codes are ones the memory supports and packs them into the address word. It then drives RAS#, CAS# and WE# low for one cycle with that word on the address pins.

The block also watches the commands that the rest of the controller places on the bus. From those it keeps one open/closed bit per bank. Programming is only allowed while every bank is closed. A request that arrives while a bank is open is held and issued as soon as all banks are closed again. After each programming cycle a lock output tells the rest of the controller that no command may go out until the settle time has passed.

Until the first programming cycle after reset, the register contents in the memory are unknown, so a flag marks the mode as valid only once one command has been issued.

Top module: `sdram_mode_prog`

## Requirements
- R1: While reset is held and in the first cycle after it, the command pins are all high, the address is zero, and `cmd_lock`, `req_pending`, `req_error` and `mode_valid` are low.
- R2: An issued command carries the burst code on address bits 2:0, the interleave bit on bit 3 and the CAS latency code on bits 6:4. All higher address bits are zero.
- R3: A programming command drives `cmd_ras_n`, `cmd_cas_n` and `cmd_we_n` all low for exactly one cycle. In every other cycle the three pins are high.
- R4: A legal request sampled while all banks are closed and the block is ready appears on the pins in the cycle right after the sampling edge.
- R5: `cmd_lock` is high in the command cycle and in the cycle after it (MRD_CYCLES = 2 cycles in total). No second command is issued while it is high.
- R6: A request sampled while `cmd_lock` or `req_pending` is high is dropped. It raises `req_error` for one cycle and issues nothing.
- R7: Supported burst codes are 000, 001, 010, 011 and 111. Supported CAS codes are 010 and 011. Any other code raises `req_error` for one cycle and issues nothing.
- R8: On the monitored bus, RAS# low with CAS# high and WE# high (activate) opens the addressed bank. RAS# low with CAS# high and WE# low (precharge) closes the addressed bank, or every bank when `mon_ap` is high.
- R9: A legal request made while any bank is open raises `req_pending`. The command is issued one cycle after the precharge that closes the last open bank, and `req_pending` then drops.
- R10: `mode_valid` stays low until the first command is issued. It is high from the command cycle on, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Programming request strobe |
| req_burst | input | 3 | Burst length code |
| req_interleave | input | 1 | 1 = interleaved order, 0 = sequential |
| req_cas | input | 3 | CAS latency code |
| mon_valid | input | 1 | A command from elsewhere is on the bus |
| mon_ras_n | input | 1 | Observed RAS# |
| mon_cas_n | input | 1 | Observed CAS# |
| mon_we_n | input | 1 | Observed WE# |
| mon_bank | input | 2 | Observed bank address |
| mon_ap | input | 1 | Observed A10 (precharge applies to all banks) |
| cmd_ras_n | output | 1 | RAS# driven by this block |
| cmd_cas_n | output | 1 | CAS# driven by this block |
| cmd_we_n | output | 1 | WE# driven by this block |
| cmd_addr | output | 12 | Mode word on the address pins |
| cmd_lock | output | 1 | No other command may be issued |
| req_pending | output | 1 | A request waits for all banks to close |
| req_error | output | 1 | One-cycle pulse for a rejected request |
| mode_valid | output | 1 | Mode register written since reset |

## Verification
The embedded assertions check the properties that hold on every cycle:
- after a command, the next cycle is locked and carries no command;
- a command only goes out when the bank state sampled on the previous cycle was all closed;
- the upper address bits are zero while a command is on the pins;
- a pending request stays pending while a bank is open;
- the valid flag never falls;
- activate and precharge-all update the bank state on the next cycle.

The exact field placement for each of the twenty legal code combinations needs the bench's directed scenarios. So do the rejection of every unsupported code, the drop of requests made while locked or pending, and the cycle on which a deferred command appears after a partial and then a full precharge.

// File: rtl/sdram_mode_pkg.sv
// Package: field layout of a mode request and the legality checks for it.
// Assumes the fields are packed with the low bits as burst, then interleave, then CAS.
package sdram_mode_pkg;

    typedef struct packed {
        logic [2:0] cas;
        logic       interleave;
        logic [2:0] burst;
    } mode_fields_t;

    localparam int FIELD_W = $bits(mode_fields_t);

    // Burst length codes the memory accepts: 1, 2, 4, 8 and full page.
    function automatic logic burst_ok(input logic [2:0] code);
        return (code inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b111});
    endfunction

    // CAS latency codes the memory accepts: 2 and 3.
    function automatic logic cas_ok(input logic [2:0] code);
        return (code inside {3'b010, 3'b011});
    endfunction

endpackage

// File: rtl/sdram_bank_tracker.sv
// Keeps one open/closed bit per bank from observed activate and precharge commands.
// Assumes the observed commands are legal and arrive at most one per cycle.
module sdram_bank_tracker
    import sdram_mode_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mon_valid,
    input  logic              mon_ras_n,
    input  logic              mon_cas_n,
    input  logic              mon_we_n,
    input  logic [BANK_W-1:0] mon_bank,
    input  logic              mon_ap,
    output logic              all_idle
);
    localparam int NUM_BANKS = 1 << BANK_W;

    logic                 is_act;
    logic                 is_pre;
    logic [NUM_BANKS-1:0] open_q;

    // Decode the two observed commands that change bank state.
    always_comb begin
        is_act = mon_valid && !mon_ras_n && mon_cas_n && mon_we_n;
        is_pre = mon_valid && !mon_ras_n && mon_cas_n && !mon_we_n;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // One bank's open bit: set on activate, cleared on its own or a global precharge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[b] <= 1'b0;
            end else if (is_act && (mon_bank == BANK_W'(b))) begin
                open_q[b] <= 1'b1;
            end else if (is_pre && (mon_ap || (mon_bank == BANK_W'(b)))) begin
                open_q[b] <= 1'b0;
            end
        end
    end

    assign all_idle = (open_q == '0);

    assert_pre_all_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pre && mon_ap) |=> all_idle);

    assert_act_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |=> !all_idle);

endmodule

// File: rtl/sdram_mode_encoder.sv
// Checks the request codes and packs them into the address word.
// Assumes ADDR_W is at least the packed field width; spare bits are driven zero.
module sdram_mode_encoder
    import sdram_mode_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  mode_fields_t      fields,
    output logic              legal,
    output logic [ADDR_W-1:0] word
);
    // Legality and packing of the request fields.
    always_comb begin
        legal               = burst_ok(fields.burst) && cas_ok(fields.cas);
        word                = '0;
        word[FIELD_W-1:0]   = fields;
    end

endmodule

// File: rtl/sdram_mrs_sequencer.sv
// Accepts, defers and issues programming requests, then holds the settle lockout.
// Assumes all_idle reflects bank state registered on the previous edge.
module sdram_mrs_sequencer
    import sdram_mode_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int MRD_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              legal,
    input  logic [ADDR_W-1:0] word,
    input  logic              all_idle,
    output logic              issue,
    output logic [ADDR_W-1:0] addr,
    output logic              lock,
    output logic              pending,
    output logic              error,
    output logic              written
);
    localparam int CNT_W = $clog2(MRD_CYCLES + 1);

    logic [CNT_W-1:0]  lock_cnt;
    logic [ADDR_W-1:0] pend_word;
    logic              ready;
    logic              take;
    logic              fire_req;
    logic              fire_pend;

    // Decide whether a request is taken and whether a command goes out this edge.
    always_comb begin
        ready     = !pending && (lock_cnt == '0);
        take      = req_valid && legal && ready;
        fire_req  = take && all_idle;
        fire_pend = pending && all_idle && (lock_cnt == '0);
    end

    // Command, lockout counter, pending slot and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue     <= 1'b0;
            addr      <= '0;
            lock_cnt  <= '0;
            pending   <= 1'b0;
            pend_word <= '0;
            error     <= 1'b0;
            written   <= 1'b0;
        end else begin
            error <= req_valid && !(legal && ready);
            issue <= fire_req || fire_pend;
            if (fire_pend) begin
                addr    <= pend_word;
                pending <= 1'b0;
            end else if (fire_req) begin
                addr <= word;
            end else begin
                addr <= '0;
            end
            if (take && !all_idle) begin
                pending   <= 1'b1;
                pend_word <= word;
            end
            if (fire_req || fire_pend) begin
                lock_cnt <= CNT_W'(MRD_CYCLES);
                written  <= 1'b1;
            end else if (lock_cnt != '0) begin
                lock_cnt <= lock_cnt - CNT_W'(1);
            end
        end
    end

    assign lock = (lock_cnt != '0);

    assert_lock_after_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (lock && !issue));

    assert_issue_needs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> $past(all_idle));

    assert_upper_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (addr[ADDR_W-1:FIELD_W] == '0));

    assert_pending_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !all_idle) |=> pending);

    assert_written_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        written |=> written);

endmodule

// File: rtl/sdram_mode_prog.sv
// Top: mode register programmer with bank-idle gating and settle lockout.
// Assumes the rest of the controller honours cmd_lock and reports its commands on mon_*.
module sdram_mode_prog
    import sdram_mode_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int BANK_W     = 2,
    parameter int MRD_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_burst,
    input  logic              req_interleave,
    input  logic [2:0]        req_cas,
    input  logic              mon_valid,
    input  logic              mon_ras_n,
    input  logic              mon_cas_n,
    input  logic              mon_we_n,
    input  logic [BANK_W-1:0] mon_bank,
    input  logic              mon_ap,
    output logic              cmd_ras_n,
    output logic              cmd_cas_n,
    output logic              cmd_we_n,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_lock,
    output logic              req_pending,
    output logic              req_error,
    output logic              mode_valid
);
    mode_fields_t      fields;
    logic              legal;
    logic [ADDR_W-1:0] word;
    logic              all_idle;
    logic              issue;

    // Gather the request fields into the packed layout.
    always_comb begin
        fields.burst      = req_burst;
        fields.interleave = req_interleave;
        fields.cas        = req_cas;
    end

    sdram_mode_encoder #(.ADDR_W(ADDR_W)) u_enc (
        .fields (fields),
        .legal  (legal),
        .word   (word)
    );

    sdram_bank_tracker #(.BANK_W(BANK_W)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_valid (mon_valid),
        .mon_ras_n (mon_ras_n),
        .mon_cas_n (mon_cas_n),
        .mon_we_n  (mon_we_n),
        .mon_bank  (mon_bank),
        .mon_ap    (mon_ap),
        .all_idle  (all_idle)
    );

    sdram_mrs_sequencer #(.ADDR_W(ADDR_W), .MRD_CYCLES(MRD_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .legal     (legal),
        .word      (word),
        .all_idle  (all_idle),
        .issue     (issue),
        .addr      (cmd_addr),
        .lock      (cmd_lock),
        .pending   (req_pending),
        .error     (req_error),
        .written   (mode_valid)
    );

    // Command pins: all three low only in the programming cycle.
    always_comb begin
        cmd_ras_n = !issue;
        cmd_cas_n = !issue;
        cmd_we_n  = !issue;
    end

endmodule

// File: tb/tb_sdram_mode_prog.sv
module tb_sdram_mode_prog;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_interleave;
    logic [2:0]  req_burst, req_cas;
    logic        mon_valid, mon_ras_n, mon_cas_n, mon_we_n, mon_ap;
    logic [1:0]  mon_bank;
    logic        cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_lock, req_pending, req_error, mode_valid;
    logic [11:0] cmd_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    sdram_mode_prog dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_burst(req_burst),
        .req_interleave(req_interleave), .req_cas(req_cas), .mon_valid(mon_valid),
        .mon_ras_n(mon_ras_n), .mon_cas_n(mon_cas_n), .mon_we_n(mon_we_n),
        .mon_bank(mon_bank), .mon_ap(mon_ap), .cmd_ras_n(cmd_ras_n),
        .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_addr(cmd_addr),
        .cmd_lock(cmd_lock), .req_pending(req_pending), .req_error(req_error),
        .mode_valid(mode_valid)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] pins();
        return {cmd_ras_n, cmd_cas_n, cmd_we_n};
    endfunction

    task automatic mon_cmd(input logic ras, input logic cas, input logic we, input logic [1:0] bank, input logic ap);
        mon_valid = 1'b1; mon_ras_n = ras; mon_cas_n = cas; mon_we_n = we;
        mon_bank = bank; mon_ap = ap;
        @(negedge clk);
        mon_valid = 1'b0; mon_ras_n = 1'b1; mon_cas_n = 1'b1; mon_we_n = 1'b1; mon_ap = 1'b0;
    endtask

    task automatic drive_req(input logic [2:0] bl, input logic il, input logic [2:0] cl);
        req_valid = 1'b1; req_burst = bl; req_interleave = il; req_cas = cl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // R1 and R10: outputs in and right after reset.
    task automatic t_reset();
        chk(pins() == 3'b111, "R1 pins in reset", pins(), 3'b111);
        chk(cmd_addr == 0 && !cmd_lock && !req_pending && !req_error, "R1 outputs in reset",
            {cmd_addr, cmd_lock, req_pending, req_error}, 0);
        chk(!mode_valid, "R10 invalid in reset", mode_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pins() == 3'b111 && !cmd_lock, "R1 idle after reset", {pins(), cmd_lock}, 4'b1110);
        chk(!mode_valid, "R10 invalid before first write", mode_valid, 0);
    endtask

    // R2 R3 R4 R5: one immediate programming cycle with full timing checks.
    task automatic issue_and_check(input logic [2:0] bl, input logic il, input logic [2:0] cl);
        logic [11:0] exp = {5'b0, cl, il, bl};
        drive_req(bl, il, cl);
        chk(pins() == 3'b000, "R3 R4 pins low in command cycle", pins(), 3'b000);
        chk(cmd_addr == exp, "R2 address encoding", cmd_addr, exp);
        chk(cmd_lock && !req_error, "R5 lock in command cycle", {cmd_lock, req_error}, 2'b10);
        chk(mode_valid, "R10 valid after write", mode_valid, 1);
        @(negedge clk);
        chk(pins() == 3'b111, "R3 single command cycle", pins(), 3'b111);
        chk(cmd_lock, "R5 lock in second cycle", cmd_lock, 1);
        @(negedge clk);
        chk(!cmd_lock, "R5 lock released", cmd_lock, 0);
    endtask

    task automatic t_encode_all();
        logic [2:0] bls [5] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b111};
        for (int i = 0; i < 5; i++)
            for (int il = 0; il < 2; il++)
                for (int cl = 2; cl < 4; cl++)
                    issue_and_check(bls[i], il[0], cl[2:0]);
    endtask

    // R6: a request during the lockout is dropped with an error pulse.
    task automatic t_busy_reject();
        drive_req(3'b010, 1'b0, 3'b011);
        chk(pins() == 3'b000, "R4 first command", pins(), 3'b000);
        drive_req(3'b011, 1'b1, 3'b010);
        chk(req_error, "R6 error while locked", req_error, 1);
        chk(pins() == 3'b111, "R6 no command while locked", pins(), 3'b111);
        @(negedge clk);
        chk(!req_error && pins() == 3'b111 && !cmd_lock, "R6 single pulse, nothing issued",
            {req_error, pins(), cmd_lock}, 5'b01110);
    endtask

    // R7: unsupported codes raise an error and issue nothing.
    task automatic t_illegal();
        for (int b = 4; b < 7; b++) begin
            drive_req(b[2:0], 1'b0, 3'b010);
            chk(req_error && pins() == 3'b111, "R7 bad burst rejected", {req_error, pins()}, 4'b1111);
            @(negedge clk);
            chk(!req_error && pins() == 3'b111, "R7 error is one cycle", {req_error, pins()}, 4'b0111);
        end
        for (int c = 0; c < 8; c++) begin
            if (c == 2 || c == 3) continue;
            drive_req(3'b000, 1'b1, c[2:0]);
            chk(req_error && pins() == 3'b111, "R7 bad CAS rejected", {req_error, pins()}, 4'b1111);
            @(negedge clk);
        end
    endtask

    // R8 R9: deferral while banks are open, release after the last precharge.
    task automatic t_defer();
        logic [11:0] exp = {5'b0, 3'b011, 1'b1, 3'b001};
        mon_cmd(1'b0, 1'b1, 1'b1, 2'd1, 1'b0);
        mon_cmd(1'b0, 1'b1, 1'b1, 2'd3, 1'b0);
        drive_req(3'b001, 1'b1, 3'b011);
        chk(req_pending && pins() == 3'b111 && !req_error, "R9 request deferred",
            {req_pending, pins(), req_error}, 5'b11110);
        repeat (3) @(negedge clk);
        chk(req_pending && pins() == 3'b111, "R9 still deferred", {req_pending, pins()}, 4'b1111);
        drive_req(3'b000, 1'b0, 3'b010);
        chk(req_error, "R6 error while pending", req_error, 1);
        mon_cmd(1'b0, 1'b1, 1'b0, 2'd1, 1'b0);
        chk(req_pending && pins() == 3'b111, "R8 one bank still open", {req_pending, pins()}, 4'b1111);
        @(negedge clk);
        chk(req_pending && pins() == 3'b111, "R8 single precharge keeps other bank", {req_pending, pins()}, 4'b1111);
        mon_cmd(1'b0, 1'b1, 1'b0, 2'd0, 1'b1);
        chk(req_pending && pins() == 3'b111, "R9 not yet issued", {req_pending, pins()}, 4'b1111);
        @(negedge clk);
        chk(pins() == 3'b000 && !req_pending, "R9 issued after precharge all", {pins(), req_pending}, 4'b0000);
        chk(cmd_addr == exp, "R2 deferred word", cmd_addr, exp);
        chk(cmd_lock, "R5 lock on deferred command", cmd_lock, 1);
        repeat (2) @(negedge clk);
        chk(!cmd_lock, "R5 lock released after deferral", cmd_lock, 0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_burst = '0; req_interleave = 1'b0; req_cas = '0;
        mon_valid = 1'b0; mon_ras_n = 1'b1; mon_cas_n = 1'b1; mon_we_n = 1'b1;
        mon_bank = '0; mon_ap = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_encode_all();
        t_busy_reject();
        t_illegal();
        t_defer();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule